// File: doc/BRIEF.md
# Auto-Wakeup Halt Controller

This block manages the deepest power-saving state of a small microcontroller. When the core issues a halt request, the controller stops the main clock and with it the CPU and every peripheral. Only a wakeup timer stays active. That timer advances on ticks from a separate low-speed oscillator, and those ticks arrive as an enable strobe on `aux_tick`. The controller leaves the halted state in three ways: when the timer reaches its programmed count, when an interrupt that is allowed to end a halt is pending, or on reset. Before the CPU clock runs again, the controller waits a stabilisation delay of 256 or 4096 CPU clock periods.

At each halt entry the controller pulses `irq_unmask` so that the core's global interrupt mask is cleared. An interrupt that is already pending therefore ends the halt straight away. A wakeup caused by the timer raises a sticky flag, and software clears that flag. A configuration option handles the case where the watchdog is running: a halt request then either produces a watchdog reset request or enters the halt state as usual.

The controller is clocked by an always-on reference clock. It drives the enables that the clock-gating cells use. The current state is visible on `mode`: 0 is run, 1 is halted and 2 is the restart delay.

Top module: `awh_ctrl`

## Requirements
- R1: `rst_n` low forces `mode`=0, `main_clk_en`=1, `cpu_clk_en`=1 and `wake_flag`=0 at once, from any state. The block stays in that state until reset is released.
- R2: In `mode`=0 a `halt_req` moves `mode` to 1 on the next clock edge, unless `wdg_en` and `wdg_halt_rst` are both 1. While `mode`=1, `main_clk_en` and `cpu_clk_en` are both 0.
- R3: Each halt entry makes `irq_unmask` high for exactly the first cycle of `mode`=1. The output is 0 at all other times.
- R4: A `halt_req` with both `wdg_en` and `wdg_halt_rst` at 1 keeps `mode` at 0 and makes `wdg_rst_req` high for exactly one cycle after the edge that took the request.
- R5: In `mode`=1 the edge that takes the P-th `aux_tick` since halt entry moves `mode` to 2, where P is `wake_period` and a value of 0 acts as 1. The tick count restarts from zero at every halt entry, and ticks outside `mode`=1 have no effect.
- R6: When `irq_exit` is 1 during `mode`=1, `mode` moves to 2 on the next edge. This includes an interrupt already pending when the halt was entered.
- R7: In `mode`=2, `main_clk_en`=1 and `cpu_clk_en`=0. The state lasts exactly 256 cycles if `dly_sel` was 0 at the exit edge, or 4096 cycles if it was 1, and then `mode` returns to 0.
- R8: `wake_flag` becomes 1 on a timer wakeup and does not change on an interrupt wakeup. It then stays 1 through the delay and run mode until a `flag_clr` pulse clears it. A timer event wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request from the core, one cycle |
| wdg_en | input | 1 | Watchdog is running |
| wdg_halt_rst | input | 1 | Option: halt with watchdog running gives a reset |
| dly_sel | input | 1 | Restart delay select: 0 = 256, 1 = 4096 cycles |
| aux_tick | input | 1 | One-cycle strobe per slow-oscillator period |
| wake_period | input | PERIOD_W | Wakeup period in slow ticks |
| irq_exit | input | 1 | Interrupt with halt-exit capability pending |
| flag_clr | input | 1 | Software clear of the wakeup flag |
| mode | output | 2 | 0 run, 1 halted, 2 restart delay |
| main_clk_en | output | 1 | Main clock / peripheral clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| irq_unmask | output | 1 | Pulse forcing the global interrupt mask to enabled |
| wdg_rst_req | output | 1 | Watchdog reset request pulse |
| wake_flag | output | 1 | Sticky timer-wakeup flag |

## Verification
Every state change and every pulse appears one edge after the input that causes it. The bench drives inputs just after a falling edge and reads the results at the following falling edge. The restart delay is measured by counting the falling edges during which `mode` reads 2. That count must equal 256 or 4096 exactly, not merely fall within a range. The wakeup timer is checked one tick at a time: the bench confirms the controller is still halted after each of the first P-1 ticks and has left the halted state right after the P-th tick. Reset is checked 1 ns after `rst_n` falls, because its effect does not wait for a clock edge.

// File: rtl/awh_pkg.sv
package awh_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAKE = 2'd2
  } awh_state_e;
endpackage

// File: rtl/awh_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module awh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/awh_wake_timer.sv
// Counts slow-oscillator ticks while halted; cleared whenever not halted.
module awh_wake_timer #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] cnt_d;
  logic [PERIOD_W:0]   cnt_inc;
  logic                cnt_en;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{PERIOD_W{1'b0}}, 1'b1};
    expire  = run_en && tick && (cnt_inc >= {1'b0, period});
    cnt_en  = !run_en || tick;
    if (!run_en || expire) cnt_d = '0;
    else                   cnt_d = cnt_inc[PERIOD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/awh_restart_delay.sv
// Down-counter that holds the CPU clock off for a selectable restart delay.
module awh_restart_delay #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_long,
  input  logic active,
  output logic done
);
  localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int DLY_W   = (MAX_DLY > 2) ? $clog2(MAX_DLY) : 1;
  localparam logic [DLY_W-1:0] SHORT_INIT = DLY_W'(SHORT_DLY - 1);
  localparam logic [DLY_W-1:0] LONG_INIT  = DLY_W'(LONG_DLY - 1);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (active && (cnt_q != '0));
    if (load) cnt_d = sel_long ? LONG_INIT : SHORT_INIT;
    else      cnt_d = cnt_q - {{(DLY_W-1){1'b0}}, 1'b1};
    done = active && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/awh_ctrl.sv
module awh_ctrl
  import awh_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int SHORT_DLY   = 256,
  parameter int LONG_DLY    = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                wdg_en,
  input  logic                wdg_halt_rst,
  input  logic                dly_sel,
  input  logic                aux_tick,
  input  logic [PERIOD_W-1:0] wake_period,
  input  logic                irq_exit,
  input  logic                flag_clr,
  output logic [1:0]          mode,
  output logic                main_clk_en,
  output logic                cpu_clk_en,
  output logic                irq_unmask,
  output logic                wdg_rst_req,
  output logic                wake_flag
);
  logic       rst_i_n;
  awh_state_e state_q, state_d;
  logic       enter_halt, wdg_trip, leave_halt;
  logic       tmr_expire, dly_done;
  logic       unmask_q, wdg_rst_q, flag_q;
  logic       flag_en, flag_d;

  awh_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  awh_wake_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .run_en (state_q == ST_HALT),
    .tick   (aux_tick),
    .period (wake_period),
    .expire (tmr_expire)
  );

  awh_restart_delay #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_delay (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (leave_halt),
    .sel_long (dly_sel),
    .active   (state_q == ST_WAKE),
    .done     (dly_done)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    enter_halt = 1'b0;
    wdg_trip   = 1'b0;
    leave_halt = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (halt_req) begin
          if (wdg_en && wdg_halt_rst) begin
            wdg_trip = 1'b1;
          end else begin
            enter_halt = 1'b1;
            state_d    = ST_HALT;
          end
        end
      end
      ST_HALT: begin
        if (tmr_expire || irq_exit) begin
          leave_halt = 1'b1;
          state_d    = ST_WAKE;
        end
      end
      ST_WAKE: begin
        if (dly_done) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  // Wakeup flag: timer event sets, software clear resets, set wins.
  always_comb begin
    flag_en = tmr_expire || flag_clr;
    flag_d  = tmr_expire;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_RUN;
      unmask_q  <= 1'b0;
      wdg_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      unmask_q  <= enter_halt;
      wdg_rst_q <= wdg_trip;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign mode        = state_q;
  assign main_clk_en = (state_q != ST_HALT);
  assign cpu_clk_en  = (state_q == ST_RUN);
  assign irq_unmask  = unmask_q;
  assign wdg_rst_req = wdg_rst_q;
  assign wake_flag   = flag_q;
endmodule

// File: rtl/awh_checker.sv
module awh_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_exit,
  input logic       flag_clr,
  input logic [1:0] mode,
  input logic       main_clk_en,
  input logic       cpu_clk_en,
  input logic       irq_unmask,
  input logic       wdg_rst_req,
  input logic       wake_flag
);
  AST_HALT_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!main_clk_en && !cpu_clk_en)); // R2

  AST_RUN_NEVER_SKIPS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode != 2'd2)); // R2

  AST_UNMASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unmask |-> ((mode == 2'd1) && ($past(mode) == 2'd0))); // R3

  AST_WDG_RST_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_req |-> ((mode == 2'd0) && ($past(mode) == 2'd0))); // R4

  AST_IRQ_EXIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1) && irq_exit) |=> (mode == 2'd2)); // R6

  AST_DELAY_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (main_clk_en && !cpu_clk_en)); // R7

  AST_DELAY_EXITS_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> ((mode == 2'd2) || (mode == 2'd0))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag && !flag_clr) |=> wake_flag); // R8
endmodule

bind awh_ctrl awh_checker u_awh_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_exit    (irq_exit),
  .flag_clr    (flag_clr),
  .mode        (mode),
  .main_clk_en (main_clk_en),
  .cpu_clk_en  (cpu_clk_en),
  .irq_unmask  (irq_unmask),
  .wdg_rst_req (wdg_rst_req),
  .wake_flag   (wake_flag)
);

// File: tb/awh_ctrl_tb_top.sv
`timescale 1ns/1ps
module awh_ctrl_tb_top;
  localparam int PW = 8;

  logic          clk;
  logic          rst_n;
  logic          halt_req, wdg_en, wdg_halt_rst, dly_sel, aux_tick, irq_exit, flag_clr;
  logic [PW-1:0] wake_period;
  logic [1:0]    mode;
  logic          main_clk_en, cpu_clk_en, irq_unmask, wdg_rst_req, wake_flag;

  int n_chk  = 0;
  int n_fail = 0;

  awh_ctrl #(.PERIOD_W(PW)) dut_i (
    .clk (clk), .rst_n (rst_n), .halt_req (halt_req), .wdg_en (wdg_en),
    .wdg_halt_rst (wdg_halt_rst), .dly_sel (dly_sel), .aux_tick (aux_tick),
    .wake_period (wake_period), .irq_exit (irq_exit), .flag_clr (flag_clr),
    .mode (mode), .main_clk_en (main_clk_en), .cpu_clk_en (cpu_clk_en),
    .irq_unmask (irq_unmask), .wdg_rst_req (wdg_rst_req), .wake_flag (wake_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {wdg_en, wdg_halt_rst, dly_sel, pre_irq, period[7:0], exp_halt, exp_flag, exp_dly[13:0]}
  localparam int NVEC = 7;
  localparam logic [27:0] VECS [0:NVEC-1] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd3, 1'b1, 1'b1, 14'd256},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'd2, 1'b1, 1'b1, 14'd4096},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'd5, 1'b1, 1'b0, 14'd256},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0, 1'b0, 14'd0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'd1, 1'b1, 1'b0, 14'd4096},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b1, 14'd256},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 14'd256}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Drives a one-cycle halt request; returns at the negedge after the accepting edge.
  task automatic pulse_halt();
    halt_req = 1'b1;
    step();
    halt_req = 1'b0;
  endtask

  // Counts cycles spent in mode 2 starting at the current negedge.
  task automatic measure_delay(output int cycles);
    cycles = 0;
    while (mode == 2'd2 && cycles < 10000) begin
      cycles++;
      step();
    end
  endtask

  task automatic give_ticks(input int n, input bool_last_wakes);
    for (int k = 1; k <= n; k++) begin
      aux_tick = 1'b1;
      step();
      aux_tick = 1'b0;
      if (k < n || !bool_last_wakes) begin
        chk("R5 still halted before last tick", mode, 1);
        step();
      end
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R8 flag cleared by software", wake_flag, 0);
  endtask

  task automatic run_vec(input int i);
    logic [27:0] v;
    int dly;
    int per;
    v = VECS[i];
    wdg_en       = v[27];
    wdg_halt_rst = v[26];
    dly_sel      = v[25];
    irq_exit     = v[24];
    wake_period  = v[23:16];
    per          = (v[23:16] == 8'd0) ? 1 : int'(v[23:16]);
    pulse_halt();
    if (!v[15]) begin
      chk("R4 watchdog trip keeps run mode", mode, 0);
      chk("R4 watchdog reset pulse", wdg_rst_req, 1);
      chk("R3 no unmask on watchdog trip", irq_unmask, 0);
      step();
      chk("R4 watchdog pulse one cycle", wdg_rst_req, 0);
      return;
    end
    chk("R2 halt entered", mode, 1);
    chk("R2 main clock off", main_clk_en, 0);
    chk("R2 cpu clock off", cpu_clk_en, 0);
    chk("R3 unmask pulse at entry", irq_unmask, 1);
    if (v[24]) begin
      step();
      irq_exit = 1'b0;
      chk("R6 pending interrupt wakes", mode, 2);
    end else begin
      give_ticks(per, 1'b1);
      chk("R5 timer wakeup after P ticks", mode, 2);
    end
    chk("R3 unmask pulse ended", irq_unmask, 0);
    chk("R7 main clock on in delay", main_clk_en, 1);
    chk("R7 cpu clock held in delay", cpu_clk_en, 0);
    chk("R8 flag after wakeup", wake_flag, int'(v[14]));
    measure_delay(dly);
    chk("R7 restart delay length", dly, int'(v[13:0]));
    chk("R7 back to run", mode, 0);
    chk("R7 cpu clock restarts", cpu_clk_en, 1);
    chk("R8 flag holds in run", wake_flag, int'(v[14]));
    if (v[14]) clear_flag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d;
    rst_n = 1'b0; halt_req = 1'b0; wdg_en = 1'b0; wdg_halt_rst = 1'b0;
    dly_sel = 1'b0; aux_tick = 1'b0; irq_exit = 1'b0; flag_clr = 1'b0;
    wake_period = 8'd1;
    repeat (3) step();
    // R1: reset state
    chk("R1 reset mode", mode, 0);
    chk("R1 reset main clock", main_clk_en, 1);
    chk("R1 reset cpu clock", cpu_clk_en, 1);
    chk("R1 reset flag", wake_flag, 0);
    rst_n = 1'b1;
    repeat (4) step();

    for (int i = 0; i < NVEC; i++) run_vec(i);

    // R5: ticks in run mode have no effect
    wdg_en = 1'b0; wdg_halt_rst = 1'b0; dly_sel = 1'b0; wake_period = 8'd1;
    for (int k = 0; k < 6; k++) begin
      aux_tick = 1'b1; step(); aux_tick = 1'b0; step();
    end
    chk("R5 ticks ignored in run", mode, 0);
    chk("R5 no flag from run ticks", wake_flag, 0);

    // R5: count restarts at every halt entry
    wake_period = 8'd4;
    pulse_halt();
    give_ticks(2, 1'b0);
    irq_exit = 1'b1; step(); irq_exit = 1'b0;
    chk("R6 interrupt exit mid-count", mode, 2);
    chk("R8 no flag on interrupt exit", wake_flag, 0);
    measure_delay(d);
    pulse_halt();
    give_ticks(3, 1'b0);
    chk("R5 count restarted after 3 ticks", mode, 1);
    give_ticks(1, 1'b1);
    chk("R5 wake on 4th tick of new halt", mode, 2);
    measure_delay(d);
    chk("R8 flag still set", wake_flag, 1);

    // R1: reset while halted clears the flag and returns to run
    pulse_halt();
    chk("R2 halted before reset", mode, 1);
    #3 rst_n = 1'b0;
    #1;
    chk("R1 reset from halt mode", mode, 0);
    chk("R1 reset from halt flag", wake_flag, 0);
    chk("R1 reset from halt main clock", main_clk_en, 1);
    step(); rst_n = 1'b1; repeat (4) step();

    // R1: reset during restart delay
    wake_period = 8'd1;
    pulse_halt();
    give_ticks(1, 1'b1);
    chk("R5 wake before reset", mode, 2);
    repeat (10) step();
    #3 rst_n = 1'b0;
    #1;
    chk("R1 reset from delay mode", mode, 0);
    chk("R1 reset from delay cpu clock", cpu_clk_en, 1);
    chk("R1 reset from delay flag", wake_flag, 0);
    step(); rst_n = 1'b1; repeat (4) step();
    chk("R1 stays in run after release", mode, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule